// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the software-visible face of a simple UART on a 32-bit bus whose addresses are byte offsets to word-aligned registers. It keeps the byte-wide registers a driver programs and polls: receive data, transmit data, interrupt enable, interrupt identification, line control, modem control, line status, modem status and the divisor. It also tracks whether the transmit holding register is empty and whether a received byte waits to be read, and it drives one level-sensitive interrupt line.

The serial side is not part of this block. A byte written by software is offered to a transmitter over a valid/ready pair, with the bits above the selected word length forced to zero. A receiver hands in each finished byte with a one-cycle valid strobe. Bit timing, the baud generator and any FIFOs belong to the neighbouring blocks. Read data and the bus error flag are registered. They appear one cycle after the access.

Top module: `uart_regfront`

## Requirements
- R1: After reset, line status reads 0x20 and every other register reads 0. The irq and tx_valid outputs are 0.
- R2: Only accesses with all four byte enables set are accepted. The register occupies bits [7:0] of the word, and read bits [31:8] are 0. The offsets are: data 0x00 (a read returns receive data, a write loads transmit data), enable 0x04, identification 0x08, line control 0x0C, modem control 0x10, line status 0x14, modem status 0x18 and divisor 0x1C. Read data appears one cycle after the access.
- R3: An access to an unmapped offset, a misaligned offset, or with partial byte enables raises bus_err for exactly one cycle. A read of that kind returns 0, and a write of that kind changes no register.
- R4: A write to offset 0x00 stores the byte, raises tx_valid, clears line status bit 5 and clears identification bit 1.
- R5: When tx_valid and tx_ready are both high, the byte is taken. In the following cycle tx_valid is low, line status bit 5 is set and the identification register holds 0x02.
- R6: Line control bits [1:0] select the word length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. tx_data carries the stored byte with every bit at or above that length forced to 0.
- R7: irq is high exactly when either of these holds: enable bit 1 and identification bit 1 are both set, or enable bit 0 and identification bit 2 are both set.
- R8: A write to the enable register with bit 1 set, while line status bit 5 is set, sets identification bit 1, so irq rises in the next cycle. A write with bit 1 clear removes the transmit interrupt.
- R9: A pulse on rx_valid stores rx_data and sets line status bit 0. If enable bit 0 is set, it also sets identification bit 2.
- R10: A read of offset 0x00 returns the stored receive byte and clears line status bit 0 and identification bit 2. If a new byte arrives in the same cycle, the arrival takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_be | input | 4 | Byte enables; only 4'hF is accepted |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Registered one-cycle error flag |
| tx_valid | output | 1 | A transmit byte is waiting |
| tx_ready | input | 1 | The transmitter takes the byte |
| tx_data | output | 8 | Transmit byte masked to the word length |
| rx_valid | input | 1 | A received byte is presented |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Level interrupt |

## Verification
The embedded properties check, on every cycle, the status and identification bits that follow a transmit load, a transmit handshake and a receive-buffer read. They also check that a rejected write leaves the registers untouched, that a rejected read returns zero, that 5-bit mode clears the upper bits of tx_data, and that clearing the enables drops irq. The bench sweeps every offset and every word length over several data patterns, computing each expected value arithmetically. Only the bench shows the whole sequences: interrupt sequencing across enable changes, the same-cycle collision of a receive-buffer read with an arriving byte, and the readback of every register.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;
  localparam int NREG  = 8;
  localparam int IDX_W = $clog2(NREG);

  typedef enum logic [IDX_W-1:0] {
    RG_DATA  = 3'd0,
    RG_IEN   = 3'd1,
    RG_IID   = 3'd2,
    RG_LCTL  = 3'd3,
    RG_MCTL  = 3'd4,
    RG_LSTAT = 3'd5,
    RG_MSTAT = 3'd6,
    RG_DIVR  = 3'd7
  } reg_idx_e;

  localparam int IEN_RX   = 0;
  localparam int IEN_TX   = 1;
  localparam int IID_TXB  = 1;
  localparam int IID_RXB  = 2;
  localparam int LST_RXRDY = 0;
  localparam int LST_THRE  = 5;
  localparam logic [7:0] IID_TX_CODE = 8'h02;
  localparam logic [7:0] LSTAT_RST   = 8'h20;
endpackage

// File: rtl/uart_rf_decode.sv
module uart_rf_decode
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  output logic              ok,
  output reg_idx_e          idx
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    ok  = sel && (be == 4'hF) && (addr[1:0] == 2'b00) && (word < WORD_W'(NREG));
    idx = reg_idx_e'(word[IDX_W-1:0]);
  end
endmodule

// File: rtl/uart_rf_txmask.sv
module uart_rf_txmask #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic [1:0]   wl,
  output logic [W-1:0] dout
);
  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [W-1:0] mask;
  always_comb begin
    mask = FULL >> (2'd3 - wl);
    dout = din & mask;
  end
endmodule

// File: rtl/uart_rf_rdmux.sv
module uart_rf_rdmux
  import uart_rf_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  reg_idx_e              idx,
  input  logic [NREG-1:0][REG_W-1:0] regs,
  output logic [REG_W-1:0]      val
);
  always_comb val = regs[idx];
endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
  import uart_rf_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [REG_W-1:0]  tx_data,
  input  logic              rx_valid,
  input  logic [REG_W-1:0]  rx_data,
  output logic              irq
);
  localparam int PAD_W = DATA_W - REG_W;

  logic [REG_W-1:0] rxbuf_q, txhold_q, ien_q, iid_q, lctl_q, mctl_q, lstat_q, mstat_q, divr_q;
  logic [REG_W-1:0] rxbuf_n, txhold_n, ien_n, iid_n, lctl_n, mctl_n, lstat_n, mstat_n, divr_n;
  logic             pend_q, pend_n;
  logic             irq_n, err_n;
  logic [DATA_W-1:0] rdata_n;

  logic             acc_ok;
  reg_idx_e         acc_idx;
  logic [REG_W-1:0] rd_val;
  logic [NREG-1:0][REG_W-1:0] reg_vec;
  logic [REG_W-1:0] wbyte;
  logic             take;

  uart_rf_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .addr(bus_addr), .be(bus_be), .ok(acc_ok), .idx(acc_idx)
  );

  always_comb begin
    reg_vec           = '0;
    reg_vec[RG_DATA]  = rxbuf_q;
    reg_vec[RG_IEN]   = ien_q;
    reg_vec[RG_IID]   = iid_q;
    reg_vec[RG_LCTL]  = lctl_q;
    reg_vec[RG_MCTL]  = mctl_q;
    reg_vec[RG_LSTAT] = lstat_q;
    reg_vec[RG_MSTAT] = mstat_q;
    reg_vec[RG_DIVR]  = divr_q;
  end

  uart_rf_rdmux #(.REG_W(REG_W)) u_mux (.idx(acc_idx), .regs(reg_vec), .val(rd_val));

  uart_rf_txmask #(.W(REG_W)) u_msk (.din(txhold_q), .wl(lctl_q[1:0]), .dout(tx_data));

  assign tx_valid = pend_q;
  assign take     = pend_q && tx_ready;
  assign wbyte    = bus_wdata[REG_W-1:0];

  // Event order within a cycle: transmit handshake, then bus access, then receive arrival.
  always_comb begin
    rxbuf_n = rxbuf_q; txhold_n = txhold_q; ien_n = ien_q; iid_n = iid_q;
    lctl_n = lctl_q; mctl_n = mctl_q; lstat_n = lstat_q; mstat_n = mstat_q;
    divr_n = divr_q; pend_n = pend_q;

    if (take) begin
      pend_n            = 1'b0;
      lstat_n[LST_THRE] = 1'b1;
      iid_n             = IID_TX_CODE;
    end

    if (acc_ok && bus_we) begin
      unique case (acc_idx)
        RG_DATA: begin
          txhold_n          = wbyte;
          pend_n            = 1'b1;
          lstat_n[LST_THRE] = 1'b0;
          iid_n[IID_TXB]    = 1'b0;
        end
        RG_IEN: begin
          ien_n = wbyte;
          if (wbyte[IEN_TX] && lstat_n[LST_THRE]) iid_n[IID_TXB] = 1'b1;
        end
        RG_IID:   iid_n   = wbyte;
        RG_LCTL:  lctl_n  = wbyte;
        RG_MCTL:  mctl_n  = wbyte;
        RG_LSTAT: lstat_n = wbyte;
        RG_MSTAT: mstat_n = wbyte;
        RG_DIVR:  divr_n  = wbyte;
        default: ;
      endcase
    end else if (acc_ok && (acc_idx == RG_DATA)) begin
      lstat_n[LST_RXRDY] = 1'b0;
      iid_n[IID_RXB]     = 1'b0;
    end

    if (rx_valid) begin
      rxbuf_n            = rx_data;
      lstat_n[LST_RXRDY] = 1'b1;
      if (ien_n[IEN_RX]) iid_n[IID_RXB] = 1'b1;
    end

    irq_n   = (ien_n[IEN_TX] && iid_n[IID_TXB]) || (ien_n[IEN_RX] && iid_n[IID_RXB]);
    rdata_n = (acc_ok && !bus_we) ? {{PAD_W{1'b0}}, rd_val} : '0;
    err_n   = bus_sel && !acc_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxbuf_q <= '0; txhold_q <= '0; ien_q <= '0; iid_q <= '0;
      lctl_q <= '0; mctl_q <= '0; lstat_q <= LSTAT_RST; mstat_q <= '0;
      divr_q <= '0; pend_q <= 1'b0; irq <= 1'b0;
      bus_rdata <= '0; bus_err <= 1'b0;
    end else begin
      rxbuf_q <= rxbuf_n; txhold_q <= txhold_n; ien_q <= ien_n; iid_q <= iid_n;
      lctl_q <= lctl_n; mctl_q <= mctl_n; lstat_q <= lstat_n; mstat_q <= mstat_n;
      divr_q <= divr_n; pend_q <= pend_n; irq <= irq_n;
      bus_rdata <= rdata_n; bus_err <= err_n;
    end
  end

  // R3
  bad_rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> (bus_rdata == '0));
  // R3
  bad_wr_inert_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && !acc_ok && !rx_valid && !take)
      |=> ($stable(ien_q) && $stable(lctl_q) && $stable(divr_q) && $stable(iid_q) && $stable(lstat_q)));
  // R4
  thr_load_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && bus_we && acc_idx == RG_DATA) |=> (tx_valid && !lstat_q[LST_THRE] && !iid_q[IID_TXB]));
  // R5
  tx_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready && !(acc_ok && bus_we)) |=> (!tx_valid && lstat_q[LST_THRE] && iid_q[IID_TXB]));
  // R6
  wl5_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (lctl_q[1:0] == 2'b00) |-> (tx_data[7:5] == 3'b000));
  // R8
  ien_off_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && bus_we && acc_idx == RG_IEN && bus_wdata[1:0] == 2'b00) |=> !irq);
  // R10
  rbr_read_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && !bus_we && acc_idx == RG_DATA && !rx_valid) |=> (!lstat_q[LST_RXRDY] && !iid_q[IID_RXB]));
endmodule

// File: tb/sim_uart_regfront.sv
module sim_uart_regfront;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, tx_valid, irq;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  tx_data, rx_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_regfront u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, got, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [5:0] a, input logic [3:0] be,
                     input logic [31:0] wd, output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_be = be; bus_wdata = wd;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    logic [31:0] rd; logic er;
    acc(1'b1, a, 4'hF, d, rd, er);
  endtask

  task automatic rdchk(input string req, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] rd; logic er;
    acc(1'b0, a, 4'hF, 32'h0, rd, er);
    check(req, $sformatf("read 0x%0h", a), rd, exp);
  endtask

  task automatic handshake();
    @(negedge clk); tx_ready = 1'b1;
    @(negedge clk); tx_ready = 1'b0;
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd; logic er;
    logic [7:0] pats [4] = '{8'hFF, 8'hA5, 8'h5A, 8'h3C};
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset values
    check("R1", "irq", {31'b0, irq}, 0);
    check("R1", "tx_valid", {31'b0, tx_valid}, 0);
    for (int i = 0; i < 8; i++) rdchk("R1", 6'(i*4), (i == 5) ? 32'h20 : 32'h0);

    // R2 readback of plain registers, upper write bits ignored
    for (int r = 0; r < 4; r++) begin
      logic [5:0] off;
      off = (r == 0) ? 6'h0C : (r == 1) ? 6'h10 : (r == 2) ? 6'h18 : 6'h1C;
      for (int p = 0; p < 4; p++) begin
        wr(off, {24'hDEADBE, pats[p]});
        rdchk("R2", off, {24'h0, pats[p]});
      end
    end
    wr(6'h08, 32'hFFFF_FF04); rdchk("R2", 6'h08, 32'h04);
    wr(6'h08, 32'h0);
    wr(6'h14, 32'h21); rdchk("R2", 6'h14, 32'h21);
    wr(6'h14, 32'h20);
    wr(6'h0C, 32'h3);

    // R3 unmapped, misaligned, partial accesses
    for (int a = 32; a < 64; a += 4) begin
      acc(1'b1, 6'(a), 4'hF, 32'hFF, rd, er);
      check("R3", "wr err", {31'b0, er}, 1);
      acc(1'b0, 6'(a), 4'hF, 32'h0, rd, er);
      check("R3", "rd err", {31'b0, er}, 1);
      check("R3", "rd data", rd, 0);
    end
    acc(1'b1, 6'h0D, 4'hF, 32'h0, rd, er); check("R3", "misaligned err", {31'b0, er}, 1);
    acc(1'b1, 6'h0C, 4'h1, 32'h0, rd, er); check("R3", "partial err", {31'b0, er}, 1);
    acc(1'b1, 6'h05, 4'hF, 32'h3, rd, er); check("R3", "misaligned ien err", {31'b0, er}, 1);
    @(negedge clk); check("R3", "err one cycle", {31'b0, bus_err}, 0);
    rdchk("R3", 6'h0C, 32'h3);
    rdchk("R3", 6'h04, 32'h0);
    rdchk("R3", 6'h00, 32'h0);

    // R4 R5 R6 R7 word-length sweep with transmit handshake
    for (int l = 0; l < 4; l++) begin
      logic [7:0] ie;
      ie = (l % 2 == 0) ? 8'h02 : 8'h00;
      wr(6'h04, {24'h0, ie});
      wr(6'h0C, 32'(l));
      for (int p = 0; p < 4; p++) begin
        wr(6'h00, {24'h0, pats[p]});
        check("R4", "tx_valid", {31'b0, tx_valid}, 1);
        check("R6", $sformatf("tx_data wl=%0d", l), {24'h0, tx_data}, {24'h0, pats[p] & 8'((1 << (5 + l)) - 1)});
        check("R7", "irq while pending", {31'b0, irq}, 0);
        rdchk("R4", 6'h14, 32'h00);
        rdchk("R4", 6'h08, 32'h00);
        handshake();
        check("R5", "tx_valid dropped", {31'b0, tx_valid}, 0);
        check("R7", "irq after take", {31'b0, irq}, {31'b0, ie[1]});
        rdchk("R5", 6'h14, 32'h20);
        rdchk("R5", 6'h08, 32'h02);
      end
    end

    // R8 enable write while idle raises irq; clear removes it
    wr(6'h04, 32'h0);
    check("R8", "irq off", {31'b0, irq}, 0);
    wr(6'h08, 32'h0);
    wr(6'h04, 32'h2);
    check("R8", "irq on at enable", {31'b0, irq}, 1);
    rdchk("R8", 6'h08, 32'h02);
    wr(6'h04, 32'h0);
    check("R8", "irq off after clear", {31'b0, irq}, 0);
    wr(6'h08, 32'h0);

    // R9 R10 receive with and without enable
    wr(6'h04, 32'h1);
    for (int p = 0; p < 4; p++) begin
      rx_byte(pats[p] ^ 8'(p));
      check("R9", "irq rx", {31'b0, irq}, 1);
      rdchk("R9", 6'h14, 32'h21);
      rdchk("R9", 6'h08, 32'h04);
      rdchk("R10", 6'h00, {24'h0, pats[p] ^ 8'(p)});
      check("R10", "irq after read", {31'b0, irq}, 0);
      rdchk("R10", 6'h14, 32'h20);
      rdchk("R10", 6'h08, 32'h00);
    end
    wr(6'h04, 32'h0);
    rx_byte(8'h4E);
    check("R9", "irq disabled", {31'b0, irq}, 0);
    rdchk("R9", 6'h14, 32'h21);
    rdchk("R9", 6'h08, 32'h00);

    // R10 read colliding with a new arrival
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 6'h00; bus_be = 4'hF; rx_valid = 1'b1; rx_data = 8'h77;
    @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0;
    check("R10", "collision old byte", bus_rdata, 32'h4E);
    rdchk("R10", 6'h14, 32'h21);
    rdchk("R10", 6'h00, 32'h77);
    rdchk("R10", 6'h14, 32'h20);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule